// File: doc/BRIEF.md
# Interrupt Delivery and Coalescing Engine

This block decides, for each of the inputs of an interrupt router, whether a line event becomes a delivered interrupt. Line events (assert, deassert) and entry-rewrite notices come in on one service port, one at a time. End-of-interrupt broadcasts come in on a second port and carry an 8-bit vector. The mask, trigger mode and vector of every routing entry are supplied as configuration inputs. The engine keeps a level bit and an in-service flag for each pin, plus one extra hold flag for a designated timer pin. When delivery is allowed, it emits a one-cycle inject pulse on that pin's output bit.

Level-triggered pins are coalesced. Once a level pin has been delivered, later asserts are held back until an end-of-interrupt with the matching vector clears its in-service flag. After every end-of-interrupt the engine walks all pins, one per cycle from pin 0 upward. Any pin whose line is still high is serviced again, so an interrupt that was coalesced during the window is delivered once the window ends. The timer pin has one extra rule: it is held back even when it is edge-triggered, and every assert on it reports to the caller whether it was delivered or coalesced.

Top module: `irq_delivery_engine`

## Requirements
- R1: After reset, every level bit, in-service flag and the timer hold flag are clear, `injectPulse` is zero, and `respValid` and `busy` are low.
- R2: A deassert clears the pin's level bit and never produces an inject pulse. A later edge assert on that pin is therefore delivered again.
- R3: An assert on an edge-triggered pin whose level bit is already set changes nothing and is reported as not delivered.
- R4: An assert sets the level bit even when the entry is masked. A masked pin never gets an inject pulse.
- R5: A delivered assert on a level-triggered pin sets that pin's in-service flag. While the flag is set, asserts on that pin are coalesced: no pulse, and delivered reads 0.
- R6: A delivered assert on the timer pin (parameter `TIMER_PIN`, default 8) sets the timer hold flag if the pin is edge-triggered. While the hold flag is set, every assert on that pin is coalesced, whatever the trigger mode.
- R7: An end-of-interrupt with vector V clears the in-service flag of every level-triggered pin whose vector is V. It clears the timer hold flag if the timer pin's vector is V. Flags of pins with other vectors are untouched.
- R8: An end-of-interrupt accepted at clock edge e0 starts a walk. Pin k is serviced as an assert at edge e(k+1), but only if its level bit is set. Any inject pulse for pin k is visible in the cycle after e(k+1).
- R9: `busy` is high for exactly `NUM_PINS` cycles after an accepted end-of-interrupt. Service requests and end-of-interrupts presented while `busy` is high are ignored.
- R10: A rewrite on a level-triggered pin whose level bit is set and which is unmasked services the pin as an assert. A rewrite while the pin is edge-triggered clears its in-service flag. Switching a pin to edge and back to level therefore acts as an implicit end-of-interrupt.
- R11: `svcKind` encodes 2'b00 as deassert, 2'b01 as assert and 2'b10 as rewrite. 2'b11, and any pin number of `NUM_PINS` or above, are ignored. Each accepted assert gives one `respValid` cycle, with `respDelivered`, in the cycle after the clock edge that samples it. Any inject pulse appears in that same cycle and lasts exactly one cycle.
- R12: When a service request and an end-of-interrupt are accepted in the same cycle, the request is judged on the flags from before the end-of-interrupt. The clearing done by the end-of-interrupt takes effect over any flag the request sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| svcValid | input | 1 | Service request present |
| svcKind | input | 2 | Request kind (see R11) |
| svcPin | input | PIN_W | Pin the request applies to |
| eoiValid | input | 1 | End-of-interrupt broadcast present |
| eoiVector | input | 8 | Vector carried by the end-of-interrupt |
| cfgMask | input | NUM_PINS | Per-pin mask, 1 = masked |
| cfgLevelTrig | input | NUM_PINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfgVector | input | NUM_PINS*8 | Per-pin vector, pin k in bits [8k+7:8k] |
| injectPulse | output | NUM_PINS | One-cycle delivery pulse per pin |
| respValid | output | 1 | Response to an accepted assert |
| respDelivered | output | 1 | 1 = delivered, 0 = ignored or coalesced |
| busy | output | 1 | Post-end-of-interrupt walk in progress |

## Verification
A line assert and an end-of-interrupt can land in the same cycle. This matters when the asserted pin is the one whose in-service flag the broadcast clears. The bench first puts a level pin in service, then presents a second assert on it together with an end-of-interrupt carrying its vector. The response must report the assert as coalesced. The walk that follows must then re-inject that pin exactly once, in its own slot and in no other.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  parameter int PIN_IDX_W = 8;
  parameter int VEC_W     = 8;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_ASSERT,
    ACT_DEASSERT,
    ACT_REWRITE,
    ACT_RESCAN
  } act_e;

  typedef struct packed {
    act_e                 act;
    logic [PIN_IDX_W-1:0] pin;
    logic                 eoi;
    logic [VEC_W-1:0]     eoiVec;
  } strobe_t;
endpackage

// File: rtl/irqd_ctrl.sv
module irqd_ctrl
  import irqd_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             svcValid,
  input  logic [1:0]       svcKind,
  input  logic [PIN_W-1:0] svcPin,
  input  logic             eoiValid,
  input  logic [VEC_W-1:0] eoiVector,
  output strobe_t          strobe,
  output logic             busy
);
  logic [PIN_W-1:0] ptr;
  logic             pinOk;

  assign pinOk = (int'(svcPin) < NUM_PINS);

  always_comb begin
    strobe        = '0;
    strobe.act    = ACT_IDLE;
    if (busy) begin
      strobe.act = ACT_RESCAN;
      strobe.pin = PIN_IDX_W'(ptr);
    end else begin
      if (svcValid && pinOk) begin
        strobe.pin = PIN_IDX_W'(svcPin);
        unique case (svcKind)
          2'b00:   strobe.act = ACT_DEASSERT;
          2'b01:   strobe.act = ACT_ASSERT;
          2'b10:   strobe.act = ACT_REWRITE;
          default: strobe.act = ACT_IDLE;
        endcase
      end
      if (eoiValid) begin
        strobe.eoi    = 1'b1;
        strobe.eoiVec = eoiVector;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else if (busy) begin
      if (ptr == PIN_W'(NUM_PINS - 1)) begin
        busy <= 1'b0;
        ptr  <= '0;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end else if (eoiValid) begin
      busy <= 1'b1;
      ptr  <= '0;
    end
  end

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> ptr == $past(ptr) + 1'b1); // R8
  AST_SCAN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> int'(ptr) < NUM_PINS); // R9
  AST_EOI_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    !busy && eoiValid |=> busy && ptr == '0); // R9
endmodule

// File: rtl/irqd_dpath.sv
module irqd_dpath
  import irqd_pkg::*;
#(
  parameter int NUM_PINS  = 24,
  parameter int TIMER_PIN = 8,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strobe,
  input  logic [NUM_PINS-1:0]       cfgMask,
  input  logic [NUM_PINS-1:0]       cfgLevelTrig,
  input  logic [NUM_PINS*VEC_W-1:0] cfgVector,
  output logic [NUM_PINS-1:0]       injectPulse,
  output logic                      respValid,
  output logic                      respDelivered
);
  logic [NUM_PINS-1:0] lvlQ, lvlD;
  logic [NUM_PINS-1:0] remQ, remSet, remClrRw, eoiHit;
  logic                tflagQ, tflagSet, tflagClr;
  logic [NUM_PINS-1:0] injD;
  logic                delivered;
  logic [VEC_W-1:0]    vecArr [NUM_PINS];
  logic [PIN_W-1:0]    pIdx;
  logic                pIsTimer, doServe, edgeRepeat, blocked;
  logic                unusedPinHi;

  assign pIdx        = strobe.pin[PIN_W-1:0];
  assign unusedPinHi = ^strobe.pin[PIN_IDX_W-1:PIN_W];
  assign pIsTimer    = (pIdx == PIN_W'(TIMER_PIN));

  for (genvar g = 0; g < NUM_PINS; g++) begin : gVec
    assign vecArr[g] = cfgVector[g*VEC_W +: VEC_W];
    assign eoiHit[g] = strobe.eoi && cfgLevelTrig[g] && (vecArr[g] == strobe.eoiVec);
  end

  assign tflagClr = strobe.eoi && (vecArr[TIMER_PIN] == strobe.eoiVec);

  always_comb begin
    lvlD      = lvlQ;
    remSet    = '0;
    remClrRw  = '0;
    tflagSet  = 1'b0;
    injD      = '0;
    delivered = 1'b0;
    blocked   = 1'b0;
    edgeRepeat = !cfgLevelTrig[pIdx] && lvlQ[pIdx];
    unique case (strobe.act)
      ACT_ASSERT:  doServe = 1'b1;
      ACT_RESCAN:  doServe = lvlQ[pIdx];
      ACT_REWRITE: doServe = cfgLevelTrig[pIdx] && lvlQ[pIdx] && !cfgMask[pIdx];
      default:     doServe = 1'b0;
    endcase
    if (strobe.act == ACT_DEASSERT) lvlD[pIdx] = 1'b0;
    if (strobe.act == ACT_REWRITE && !cfgLevelTrig[pIdx]) remClrRw[pIdx] = 1'b1;
    if (doServe && !edgeRepeat) begin
      lvlD[pIdx] = 1'b1;
      blocked = cfgMask[pIdx] || (cfgLevelTrig[pIdx] && remQ[pIdx]) || (pIsTimer && tflagQ);
      if (!blocked) begin
        injD[pIdx] = 1'b1;
        delivered  = 1'b1;
        if (cfgLevelTrig[pIdx]) remSet[pIdx] = 1'b1;
        else if (pIsTimer)      tflagSet     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvlQ          <= '0;
      remQ          <= '0;
      tflagQ        <= 1'b0;
      injectPulse   <= '0;
      respValid     <= 1'b0;
      respDelivered <= 1'b0;
    end else begin
      lvlQ          <= lvlD;
      remQ          <= (remQ | remSet) & ~(eoiHit | remClrRw);
      tflagQ        <= (tflagQ | tflagSet) & ~tflagClr;
      injectPulse   <= injD;
      respValid     <= (strobe.act == ACT_ASSERT);
      respDelivered <= (strobe.act == ACT_ASSERT) && delivered;
    end
  end

  AST_INJ_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(injectPulse)); // R11
  AST_DEASSERT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.act == ACT_DEASSERT |=> injectPulse == '0); // R2
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.act == ACT_ASSERT || strobe.act == ACT_RESCAN) && cfgMask[pIdx] |=> injectPulse == '0); // R4
  AST_LEVEL_COALESCE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.act == ACT_ASSERT && cfgLevelTrig[pIdx] && remQ[pIdx] |=> injectPulse == '0 && !respDelivered); // R5
  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.act == ACT_ASSERT && pIsTimer && tflagQ |=> injectPulse == '0); // R6
endmodule

// File: rtl/irq_delivery_engine.sv
module irq_delivery_engine
  import irqd_pkg::*;
#(
  parameter int NUM_PINS  = 24,
  parameter int TIMER_PIN = 8,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      svcValid,
  input  logic [1:0]                svcKind,
  input  logic [PIN_W-1:0]          svcPin,
  input  logic                      eoiValid,
  input  logic [VEC_W-1:0]          eoiVector,
  input  logic [NUM_PINS-1:0]       cfgMask,
  input  logic [NUM_PINS-1:0]       cfgLevelTrig,
  input  logic [NUM_PINS*VEC_W-1:0] cfgVector,
  output logic [NUM_PINS-1:0]       injectPulse,
  output logic                      respValid,
  output logic                      respDelivered,
  output logic                      busy
);
  strobe_t strobe;

  irqd_ctrl #(.NUM_PINS(NUM_PINS)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .svcValid  (svcValid),
    .svcKind   (svcKind),
    .svcPin    (svcPin),
    .eoiValid  (eoiValid),
    .eoiVector (eoiVector),
    .strobe    (strobe),
    .busy      (busy)
  );

  irqd_dpath #(.NUM_PINS(NUM_PINS), .TIMER_PIN(TIMER_PIN)) uDpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .cfgMask       (cfgMask),
    .cfgLevelTrig  (cfgLevelTrig),
    .cfgVector     (cfgVector),
    .injectPulse   (injectPulse),
    .respValid     (respValid),
    .respDelivered (respDelivered)
  );

  AST_RESP_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> !respValid); // R9
endmodule

// File: tb/irq_delivery_engine_test.sv
`timescale 1ns/1ps
module irq_delivery_engine_test;
  localparam int N  = 24;
  localparam int TP = 8;
  localparam int PW = $clog2(N);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            svcValid = 1'b0;
  logic [1:0]      svcKind = 2'b00;
  logic [PW-1:0]   svcPin = '0;
  logic            eoiValid = 1'b0;
  logic [7:0]      eoiVector = '0;
  logic [N-1:0]    cfgMask = '0;
  logic [N-1:0]    cfgLevelTrig = '0;
  logic [N*8-1:0]  cfgVector;
  logic [N-1:0]    injectPulse;
  logic            respValid, respDelivered, busy;

  int nChk = 0;
  int nFail = 0;
  bit mLvl [N];
  bit mRem [N];
  bit mTf;

  always #4 clk = ~clk;

  irq_delivery_engine #(.NUM_PINS(N), .TIMER_PIN(TP)) uut (
    .clk(clk), .rstN(rstN), .svcValid(svcValid), .svcKind(svcKind), .svcPin(svcPin),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .cfgMask(cfgMask),
    .cfgLevelTrig(cfgLevelTrig), .cfgVector(cfgVector), .injectPulse(injectPulse),
    .respValid(respValid), .respDelivered(respDelivered), .busy(busy)
  );

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] vecOf(int i);
    return cfgVector[i*8 +: 8];
  endfunction

  task automatic mServe(int p, output bit del, output logic [N-1:0] inj);
    del = 1'b0;
    inj = '0;
    if (!(!cfgLevelTrig[p] && mLvl[p])) begin
      mLvl[p] = 1'b1;
      if (!(cfgMask[p] || (cfgLevelTrig[p] && mRem[p]) || (p == TP && mTf))) begin
        del = 1'b1;
        inj[p] = 1'b1;
        if (cfgLevelTrig[p]) mRem[p] = 1'b1;
        else if (p == TP) mTf = 1'b1;
      end
    end
  endtask

  task automatic mEoi(logic [7:0] v);
    if (vecOf(TP) == v) mTf = 1'b0;
    for (int i = 0; i < N; i++)
      if (cfgLevelTrig[i] && vecOf(i) == v) mRem[i] = 1'b0;
  endtask

  task automatic mSvc(logic [1:0] kind, int p, output logic [N-1:0] inj,
                      output bit rv, output bit del);
    inj = '0; rv = 1'b0; del = 1'b0;
    if (p < N) begin
      case (kind)
        2'b00: mLvl[p] = 1'b0;
        2'b01: begin rv = 1'b1; mServe(p, del, inj); end
        2'b10: begin
          if (!cfgLevelTrig[p]) mRem[p] = 1'b0;
          if (cfgLevelTrig[p] && mLvl[p] && !cfgMask[p]) mServe(p, del, inj);
          del = 1'b0;
        end
        default: ;
      endcase
    end
  endtask

  // Walk after an accepted end-of-interrupt (R8, R9); optionally pokes requests while busy.
  task automatic scanCheck(string tag, bit poke);
    for (int k = 0; k < N; k++) begin
      logic [N-1:0] inj;
      bit del;
      @(negedge clk);
      inj = '0;
      if (mLvl[k]) mServe(k, del, inj);
      check(injectPulse == inj && busy == (k < N-1) && !respValid,
            {tag, " R8 R9 walk"}, {respValid, busy, injectPulse},
            {1'b0, (k < N-1), inj});
      if (poke && k == 2) begin
        svcValid = 1'b1; svcKind = 2'b01; svcPin = PW'(20);
        eoiValid = 1'b1; eoiVector = vecOf(20);
      end
      if (poke && k == 3) begin
        svcValid = 1'b0; eoiValid = 1'b0;
      end
    end
  endtask

  task automatic doSvc(logic [1:0] kind, int p, string tag);
    logic [N-1:0] inj;
    bit rv, del;
    mSvc(kind, p, inj, rv, del);
    @(negedge clk);
    svcValid = 1'b1; svcKind = kind; svcPin = PW'(p);
    @(negedge clk);
    svcValid = 1'b0;
    check(injectPulse == inj && respValid == rv && (!rv || respDelivered == del),
          tag, {respValid, respDelivered, injectPulse}, {rv, del, inj});
  endtask

  task automatic doEoi(logic [7:0] v, string tag, bit poke);
    mEoi(v);
    @(negedge clk);
    eoiValid = 1'b1; eoiVector = v;
    @(negedge clk);
    eoiValid = 1'b0;
    scanCheck({tag, " R7"}, poke);
  endtask

  task automatic doBoth(int p, logic [7:0] v, string tag);
    logic [N-1:0] inj;
    bit rv, del;
    mSvc(2'b01, p, inj, rv, del);
    mEoi(v);
    @(negedge clk);
    svcValid = 1'b1; svcKind = 2'b01; svcPin = PW'(p);
    eoiValid = 1'b1; eoiVector = v;
    @(negedge clk);
    svcValid = 1'b0; eoiValid = 1'b0;
    check(injectPulse == inj && respValid && respDelivered == del,
          tag, {respValid, respDelivered, injectPulse}, {1'b1, del, inj});
    scanCheck(tag, 1'b0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < N; i++) begin mLvl[i] = 1'b0; mRem[i] = 1'b0; end
    mTf = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) cfgVector[i*8 +: 8] = 8'(8'h20 + i);
    doReset();
    @(negedge clk);
    check(injectPulse == '0 && !respValid && !busy, "R1 reset",
          {respValid, busy, injectPulse}, 64'h0);

    // Near-exhaustive sweep: every pin, every mask/trigger combination.
    for (int p = 0; p < N; p++) begin
      for (int c = 0; c < 4; c++) begin
        cfgMask[p] = c[0];
        cfgLevelTrig[p] = c[1];
        doSvc(2'b01, p, "R4 R5 R11 sweep assert");
        doSvc(2'b01, p, "R3 R5 sweep repeat");
        doSvc(2'b00, p, "R2 sweep deassert");
        doSvc(2'b01, p, "R2 R3 sweep re-assert");
        cfgMask[p] = 1'b0;
        doSvc(2'b10, p, "R10 sweep rewrite");
        doEoi(vecOf(p), "sweep eoi", 1'b0);
        doSvc(2'b00, p, "R2 sweep drop");
        cfgLevelTrig[p] = 1'b0;
      end
    end

    // Timer pin hold flag.
    doReset();
    doSvc(2'b01, TP, "R6 timer first");
    doSvc(2'b00, TP, "R6 timer drop");
    doSvc(2'b01, TP, "R6 timer held");
    doSvc(2'b00, TP, "R6 timer drop2");
    doEoi(8'h37, "R6 foreign vector", 1'b0);
    doSvc(2'b01, TP, "R6 R7 still held");
    doSvc(2'b00, TP, "R6 drop3");
    doEoi(vecOf(TP), "R6 matching", 1'b0);
    doSvc(2'b01, TP, "R6 R7 released");

    // Implicit end-of-interrupt through edge and back.
    cfgLevelTrig[5] = 1'b1;
    doSvc(2'b01, 5, "R10 level fire");
    doSvc(2'b01, 5, "R5 coalesced");
    cfgLevelTrig[5] = 1'b0;
    doSvc(2'b10, 5, "R10 to edge");
    cfgLevelTrig[5] = 1'b1;
    doSvc(2'b10, 5, "R10 back to level fires");

    // Masked level pin fires on unmask.
    cfgLevelTrig[12] = 1'b1; cfgMask[12] = 1'b1;
    doSvc(2'b01, 12, "R4 masked");
    cfgMask[12] = 1'b0;
    doSvc(2'b10, 12, "R4 R10 unmask fires");

    // Two pins on one vector: walk order.
    cfgLevelTrig[2] = 1'b1; cfgLevelTrig[17] = 1'b1;
    cfgVector[2*8 +: 8] = 8'h50; cfgVector[17*8 +: 8] = 8'h50;
    doSvc(2'b01, 2, "R5 pin2");
    doSvc(2'b01, 17, "R5 pin17");
    doEoi(8'h50, "R8 shared vector", 1'b0);

    // Same-cycle request and end-of-interrupt.
    cfgLevelTrig[3] = 1'b1; cfgVector[3*8 +: 8] = 8'h40;
    doSvc(2'b01, 3, "R12 prime");
    doBoth(3, 8'h40, "R12 same cycle");

    // Requests while busy are dropped.
    doEoi(8'h99, "R9 poke", 1'b1);
    doSvc(2'b01, 20, "R9 pin20 untouched");

    // Reserved kind and out-of-range pin.
    doSvc(2'b11, 6, "R11 reserved kind");
    doSvc(2'b01, 30, "R11 pin out of range");
    doSvc(2'b01, 6, "R11 pin6 after reserved");

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule